// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Adapter

This adapter sits in front of a word-wide backing memory that only accepts whole-word writes, for example a scratchpad whose check bits span the full word. Upstream masters still issue byte-granular writes with a per-byte strobe. Reads and writes with every strobe bit set pass straight through to the memory in the same cycle, with no added latency.

A write whose strobe is not all ones is accepted at once and latched. The adapter then runs a three-step sequence of its own. It reads the target word, merges the new bytes into the returned word under the latched strobe, and writes the merged word back as a full word. The upstream grant stays low until that write-back has been issued. The memory port has no strobe, and the data the adapter reads for itself is never reported upstream as a read response.

The memory is expected to return read data exactly one cycle after it grants a read, and to give no response to writes.

Top module: `rmw_adapter`

## Requirements
- R1: While no merge sequence is running, a read or a write with all strobe bits set is forwarded in the same cycle. `memReq_o` follows `upReq_i`, and address, write enable and write data are copied to the memory port. `upGnt_o` equals `memGnt_i`.
- R2: Upstream read data is the memory read data. `upRvalid_o` is high in the cycle after a granted upstream read, together with the data of the addressed word.
- R3: A write whose strobe is not all ones, including all zeros, is granted in the cycle it is presented while no sequence is running. It causes no memory access in that cycle.
- R4: In the cycle after a partial write is accepted, the adapter issues a memory read (`memWe_o` low) at the latched address. It holds that read until `memGnt_i` is high.
- R5: The response to the adapter's own read never raises `upRvalid_o`.
- R6: The write-back has `memWe_o` high and goes to the latched address. Byte lane b (data bits 8b+7 to 8b) comes from the latched write data when strobe bit b is 1, and from the word just read otherwise. It is held until granted.
- R7: `upGnt_o` is low from the cycle after a partial write is accepted until the cycle after its write-back is granted. Requests from that point on are handled normally again.
- R8: Address, data and strobe of a partial write are latched when it is accepted. Upstream inputs that change during the sequence do not alter the read or the merged write.
- R9: After reset no sequence is running, `upRvalid_o` is low, and no memory request is made without an upstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upReq_i | input | 1 | Upstream request |
| upGnt_o | output | 1 | Upstream grant |
| upAddr_i | input | AW | Upstream byte address |
| upWe_i | input | 1 | Upstream write enable |
| upWdata_i | input | DW | Upstream write data |
| upStrb_i | input | DW/8 | Upstream byte strobe |
| upRvalid_o | output | 1 | Upstream read response valid |
| upRdata_o | output | DW | Upstream read data |
| memReq_o | output | 1 | Memory request |
| memGnt_i | input | 1 | Memory grant |
| memAddr_o | output | AW | Memory address |
| memWe_o | output | 1 | Memory write enable (always full word) |
| memWdata_o | output | DW | Memory write data |
| memRvalid_i | input | 1 | Memory read valid, one cycle after a granted read |
| memRdata_i | input | DW | Memory read data |

## Verification
Two kinds of faults can occur in the internal state. A sequencer stuck in or skipping a step shows at the ports within one cycle: the grant is wrong, the read or write-back is missing, or the write-back is too early. A wrong latched value or merge shows as a bad write-back word in that same write cycle, and again on every later read of that word. A tag fault on the internal read shows as a spurious `upRvalid_o` one cycle after that read is granted. The bench checks grant, request fields, write-back word and read responses on every cycle, so each of these faults is caught on the cycle it first appears.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } rmwState_e;

  typedef struct packed {
    logic capture;    // latch address/data/strobe of a partial write
    logic loadMerge;  // register merged word from read data
    logic drive;      // memory port driven from latched values
    logic intWe;      // write enable of internal access
  } rmwCtl_t;
endpackage

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rmwCtl_t           ctl_i,
  input  logic [AW-1:0]     upAddr_i,
  input  logic [DW-1:0]     upWdata_i,
  input  logic [DW/8-1:0]   upStrb_i,
  input  logic              upWe_i,
  input  logic [DW-1:0]     memRdata_i,
  output logic              fullStrb_o,
  output logic [AW-1:0]     memAddr_o,
  output logic [DW-1:0]     memWdata_o,
  output logic              memWe_o
);
  localparam int NB = DW / 8;

  logic [AW-1:0] addrQ;
  logic [DW-1:0] dataQ;
  logic [NB-1:0] strbQ;
  logic [DW-1:0] mergedQ;
  logic [DW-1:0] mergeComb;

  assign fullStrb_o = &upStrb_i;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign mergeComb[8*b +: 8] = strbQ[b] ? dataQ[8*b +: 8] : memRdata_i[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addrQ   <= '0;
      dataQ   <= '0;
      strbQ   <= '0;
      mergedQ <= '0;
    end else begin
      if (ctl_i.capture) begin
        addrQ <= upAddr_i;
        dataQ <= upWdata_i;
        strbQ <= upStrb_i;
      end
      if (ctl_i.loadMerge) begin
        mergedQ <= mergeComb;
      end
    end
  end

  always_comb begin
    if (ctl_i.drive) begin
      memAddr_o  = addrQ;
      memWdata_o = mergedQ;
      memWe_o    = ctl_i.intWe;
    end else begin
      memAddr_o  = upAddr_i;
      memWdata_o = upWdata_i;
      memWe_o    = upWe_i;
    end
  end
endmodule

// File: rtl/rmw_control.sv
module rmw_control
  import rmw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    upReq_i,
  input  logic    upWe_i,
  input  logic    fullStrb_i,
  input  logic    memGnt_i,
  input  logic    memRvalid_i,
  output rmwCtl_t ctl_o,
  output logic    upGnt_o,
  output logic    memReq_o,
  output logic    hideRvalid_o
);
  rmwState_e stateQ, stateD;
  logic ownReadQ, ownReadD;

  always_comb begin
    stateD   = stateQ;
    ctl_o    = '0;
    upGnt_o  = 1'b0;
    memReq_o = 1'b0;
    ownReadD = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (upReq_i && upWe_i && !fullStrb_i) begin
          ctl_o.capture = 1'b1;
          upGnt_o       = 1'b1;
          stateD        = ST_READ;
        end else begin
          memReq_o = upReq_i;
          upGnt_o  = memGnt_i;
        end
      end
      ST_READ: begin
        ctl_o.drive = 1'b1;
        memReq_o    = 1'b1;
        if (memGnt_i) begin
          ownReadD = 1'b1;
          stateD   = ST_MERGE;
        end
      end
      ST_MERGE: begin
        if (memRvalid_i) begin
          ctl_o.loadMerge = 1'b1;
          stateD          = ST_WRITE;
        end
      end
      ST_WRITE: begin
        ctl_o.drive = 1'b1;
        ctl_o.intWe = 1'b1;
        memReq_o    = 1'b1;
        if (memGnt_i) begin
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stateQ   <= ST_IDLE;
      ownReadQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      ownReadQ <= ownReadD;
    end
  end

  assign hideRvalid_o = ownReadQ;
endmodule

// File: rtl/rmw_adapter.sv
module rmw_adapter
  import rmw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upReq_i,
  output logic             upGnt_o,
  input  logic [AW-1:0]    upAddr_i,
  input  logic             upWe_i,
  input  logic [DW-1:0]    upWdata_i,
  input  logic [DW/8-1:0]  upStrb_i,
  output logic             upRvalid_o,
  output logic [DW-1:0]    upRdata_o,
  output logic             memReq_o,
  input  logic             memGnt_i,
  output logic [AW-1:0]    memAddr_o,
  output logic             memWe_o,
  output logic [DW-1:0]    memWdata_o,
  input  logic             memRvalid_i,
  input  logic [DW-1:0]    memRdata_i
);
  rmwCtl_t ctl;
  logic    fullStrb;
  logic    hideRvalid;

  rmw_control u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upReq_i      (upReq_i),
    .upWe_i       (upWe_i),
    .fullStrb_i   (fullStrb),
    .memGnt_i     (memGnt_i),
    .memRvalid_i  (memRvalid_i),
    .ctl_o        (ctl),
    .upGnt_o      (upGnt_o),
    .memReq_o     (memReq_o),
    .hideRvalid_o (hideRvalid)
  );

  rmw_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl),
    .upAddr_i   (upAddr_i),
    .upWdata_i  (upWdata_i),
    .upStrb_i   (upStrb_i),
    .upWe_i     (upWe_i),
    .memRdata_i (memRdata_i),
    .fullStrb_o (fullStrb),
    .memAddr_o  (memAddr_o),
    .memWdata_o (memWdata_o),
    .memWe_o    (memWe_o)
  );

  assign upRvalid_o = memRvalid_i & ~hideRvalid;
  assign upRdata_o  = memRdata_i;
endmodule

// File: rtl/rmw_adapter_chk.sv
module rmw_adapter_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            upReq_i,
  input logic            upGnt_o,
  input logic [AW-1:0]   upAddr_i,
  input logic            upWe_i,
  input logic [DW-1:0]   upWdata_i,
  input logic [DW/8-1:0] upStrb_i,
  input logic            upRvalid_o,
  input logic            memReq_o,
  input logic            memGnt_i,
  input logic [AW-1:0]   memAddr_o,
  input logic            memWe_o,
  input logic [DW-1:0]   memWdata_o,
  input logic            memRvalid_i
);
  logic partialAcc;
  assign partialAcc = upReq_i && upGnt_o && upWe_i && !(&upStrb_i);

  p_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upReq_i && upGnt_o && (!upWe_i || (&upStrb_i))) |->
      (memReq_o && memAddr_o == upAddr_i && memWe_o == upWe_i && memWdata_o == upWdata_i));

  p_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upReq_i && upGnt_o && !upWe_i) |=> (upRvalid_o == memRvalid_i));

  p_nomem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    partialAcc |-> !memReq_o);

  p_intread_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    partialAcc |=> (memReq_o && !memWe_o && memAddr_o == $past(upAddr_i)));

  p_hide_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memReq_o && memGnt_i && !memWe_o && !upGnt_o) |=> !upRvalid_o);

  p_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    partialAcc |=> !upGnt_o);
endmodule

bind rmw_adapter rmw_adapter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upReq_i     (upReq_i),
  .upGnt_o     (upGnt_o),
  .upAddr_i    (upAddr_i),
  .upWe_i      (upWe_i),
  .upWdata_i   (upWdata_i),
  .upStrb_i    (upStrb_i),
  .upRvalid_o  (upRvalid_o),
  .memReq_o    (memReq_o),
  .memGnt_i    (memGnt_i),
  .memAddr_o   (memAddr_o),
  .memWe_o     (memWe_o),
  .memWdata_o  (memWdata_o),
  .memRvalid_i (memRvalid_i)
);

// File: tb/rmw_adapter_test.sv
module rmw_adapter_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic upReq, upGnt, upWe, upRvalid;
  logic [AW-1:0] upAddr;
  logic [DW-1:0] upWdata, upRdata;
  logic [3:0] upStrb;
  logic mReq, mGnt, mWe, mRv;
  logic [AW-1:0] mAddr;
  logic [DW-1:0] mWdata, mRdata;

  rmw_adapter #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rstN),
    .upReq_i(upReq), .upGnt_o(upGnt), .upAddr_i(upAddr), .upWe_i(upWe),
    .upWdata_i(upWdata), .upStrb_i(upStrb), .upRvalid_o(upRvalid), .upRdata_o(upRdata),
    .memReq_o(mReq), .memGnt_i(mGnt), .memAddr_o(mAddr), .memWe_o(mWe),
    .memWdata_o(mWdata), .memRvalid_i(mRv), .memRdata_i(mRdata)
  );

  // backing memory: read data one cycle after a granted read
  logic [DW-1:0] store [16];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRv <= 1'b0;
      mRdata <= '0;
    end else begin
      mRv <= mReq && mGnt && !mWe;
      if (mReq && mGnt) begin
        if (mWe) store[mAddr[5:2]] <= mWdata;
        else mRdata <= store[mAddr[5:2]];
      end
    end
  end

  // reference model
  logic [DW-1:0] golden [16];
  int phase = 0;
  logic [AW-1:0] pAddr;
  logic [DW-1:0] expMerged;
  logic expRv = 1'b0;
  logic [DW-1:0] expRd;
  int stallCnt = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit lastAcc;

  function automatic logic [DW-1:0] mergeWord(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] s);
    logic [DW-1:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doCycle(input bit req, input bit we, input int idx, input logic [DW-1:0] d, input logic [3:0] s);
    bit g, sGnt, partial;
    @(negedge clk);
    g = (stallCnt == 0);
    if (stallCnt > 0) stallCnt--;
    upReq = req; upWe = we; upAddr = AW'(idx * 4); upWdata = d; upStrb = s; mGnt = g;
    #5;
    sGnt = upGnt;
    partial = req && we && (s != 4'hF);
    if (phase == 0) begin
      chk(upGnt == (partial ? 1'b1 : g), partial ? "R3 grant" : "R1 grant", upGnt, partial ? 1 : g);
      if (!req) chk(mReq == 1'b0, "R9 idle memReq", mReq, 0);
      else if (partial) chk(mReq == 1'b0, "R3 no access", mReq, 0);
      else chk(mReq && mAddr == upAddr && mWe == we && (!we || mWdata == d),
               "R1 forward", mAddr, upAddr);
    end else begin
      chk(upGnt == 1'b0, "R7 stall", upGnt, 0);
    end
    if (phase == 1) chk(mReq && !mWe && mAddr == pAddr, "R4 R8 internal read", mAddr, pAddr);
    if (phase == 3) begin
      chk(mReq && mWe && mAddr == pAddr, "R6 R8 write-back addr", mAddr, pAddr);
      chk(mWdata == expMerged, "R6 merged word", mWdata, expMerged);
    end
    chk(upRvalid == expRv, expRv ? "R2 rvalid" : "R5 rvalid hidden", upRvalid, expRv);
    if (expRv) chk(upRdata == expRd, "R2 rdata", upRdata, expRd);
    @(posedge clk);
    #1;
    expRv = 1'b0;
    lastAcc = 0;
    case (phase)
      0: if (req) begin
           if (partial) begin
             pAddr = AW'(idx * 4);
             expMerged = mergeWord(golden[idx], d, s);
             golden[idx] = expMerged;
             phase = 1;
             lastAcc = 1;
           end else if (sGnt) begin
             lastAcc = 1;
             if (we) golden[idx] = d;
             else begin expRv = 1'b1; expRd = golden[idx]; end
           end
         end
      1: if (g) phase = 2;
      2: phase = 3;
      default: if (g) phase = 0;
    endcase
  endtask

  task automatic doReq(input bit we, input int idx, input logic [DW-1:0] d, input logic [3:0] s);
    lastAcc = 0;
    while (!lastAcc) doCycle(1'b1, we, idx, d, s);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog actual %0d expected <20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    upReq = 0; upWe = 0; upAddr = '0; upWdata = '0; upStrb = '0; mGnt = 1;
    for (int i = 0; i < 16; i++) begin
      store[i] = 32'h1000_0000 + i * 32'h0101_0101;
      golden[i] = 32'h1000_0000 + i * 32'h0101_0101;
    end
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R9: reset state
    doCycle(0, 0, 0, 0, 0);
    doCycle(0, 0, 0, 0, 0);
    // R1 R2: plain reads and full write
    for (int i = 0; i < 4; i++) doReq(0, i, 0, 0);
    doReq(1, 1, 32'hA5A5_0001, 4'hF);
    doReq(0, 1, 0, 0);
    // R3 R4 R5 R6 R7: partial writes with various strobes, back-to-back
    doReq(1, 2, 32'h1111_11EE, 4'h1);
    doReq(1, 2, 32'hCC33_DD44, 4'hA);
    doReq(0, 2, 0, 0);
    doReq(1, 3, 32'hDEAD_BEEF, 4'h0);
    doReq(1, 4, 32'h7766_5544, 4'hE);
    doReq(1, 5, 32'h0BAD_F00D, 4'hF);
    // R4 R6: memory stalls during internal read
    stallCnt = 3;
    doReq(1, 6, 32'h55AA_66BB, 4'h6);
    stallCnt = 2;
    doReq(0, 6, 0, 0);
    doReq(1, 7, 32'h0102_0304, 4'h9);
    doReq(1, 8, 32'hFFFF_FFFF, 4'h8);
    // R8: upstream inputs move while sequence runs (next request differs)
    doReq(1, 9, 32'h9999_9999, 4'h3);
    doReq(1, 10, 32'h1234_5678, 4'hF);
    for (int i = 0; i < 16; i++) doReq(0, i, 0, 0);
    doCycle(0, 0, 0, 0, 0);
    doCycle(0, 0, 0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule